// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This block takes one IEEE-754 operand in half, single or double precision and returns the nearest integral value in the same format. The rounding rule comes from a 3-bit mode field. That field either names a static rule, forces round-to-nearest with ties away from zero, or defers to a 2-bit dynamic mode input. The dynamic selection comes in two variants: one reports an inexact result and one stays silent. Zeros, infinities and NaNs get their own handling. A signalling NaN raises the invalid flag.

The result is written into the lowest element of a 128-bit destination vector. The bits above that element are either copied from the previous destination value or cleared, as chosen by a merge input. The operand and controls are taken on a cycle where `in_valid` is high. The vector, the flags and `out_valid` appear one clock later. Illegal format or mode encodings raise `undef`. In that case the vector and both flags are forced to zero.

Top module: `fp_round_integral`

## Requirements
- R1: `fmt_code` selects the operand width: 00 single (32 bit), 01 double (64 bit), 11 half (16 bit, present with HALF_EN=1, the default). Code 10 raises `undef`, and then `result`, `flag_invalid` and `flag_inexact` are all zero.
- R2: `mode_field` decodes as follows. 0xx uses bits [1:0] as a static rule (00 nearest-even, 01 toward +infinity, 10 toward -infinity, 11 toward zero). 100 is nearest with ties away from zero. 110 and 111 use `dyn_mode`, which has the same 2-bit encoding. 101 raises `undef`.
- R3: In ties-away rounding, a value exactly halfway between two integers goes to the one of larger magnitude (2.5 gives 3.0, -2.5 gives -3.0).
- R4: In nearest-even rounding, a halfway value goes to the even neighbour (2.5 gives 2.0, 3.5 gives 4.0). A value above the midpoint goes up.
- R5: A zero or infinite operand is returned unchanged, with its sign kept.
- R6: A signalling NaN (top fraction bit 0, fraction nonzero) is returned with the top fraction bit set and raises `flag_invalid`. A quiet NaN is returned unchanged with no flag.
- R7: An operand whose unbiased exponent is at least the fraction width is returned unchanged and never reports inexact.
- R8: A nonzero operand of magnitude below one, subnormals included, becomes zero or one with its sign kept (-0.3 toward zero gives -0.0, -0.3 toward -infinity gives -1.0).
- R9: When rounding up carries out of the significand, the exponent goes up by one and the fraction becomes zero (1.5 nearest-even gives 2.0, 1.75 toward +infinity gives 2.0).
- R10: `flag_inexact` is high only when `mode_field` is 110 and the result differs from the operand.
- R11: `result` bits above the element width are taken from `dest_old` when `merge_en` is 1 and are zero when it is 0.
- R12: Outputs change one clock after an `in_valid` cycle, and `out_valid` is high in exactly that cycle. After reset, `out_valid`, `result` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| fmt_code | input | 2 | Operand format code |
| mode_field | input | 3 | Rounding mode field |
| dyn_mode | input | 2 | Dynamic rounding rule used by field values 110 and 111 |
| merge_en | input | 1 | Keep upper destination bits (1) or clear them (0) |
| operand | input | 64 | Operand, right-aligned for narrow formats |
| dest_old | input | 128 | Previous destination vector |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| result | output | 128 | Destination vector with the rounded element in the low bits |
| undef | output | 1 | Illegal format or mode encoding |
| flag_invalid | output | 1 | Signalling NaN seen |
| flag_inexact | output | 1 | Rounded value differs from operand (field 110 only) |

## Verification
The bench targets halfway operands, where confusing ties-away with nearest-even turns 2.5 into the wrong neighbour. It also targets carry into a new binade, where a design that forgets to bump the exponent returns 1.0 or garbage in place of 2.0 and 4.0. Operands below one in magnitude are run under every rule; a design that drops the sign there returns +0.0 for -0.3. The bench also covers the NaN split, the silent dynamic variant (a leaked inexact flag shows up at once), and merge against zeroing in all three widths. A wrong element-width mask would corrupt the upper vector bits.

// File: rtl/fpri_pkg.sv
package fpri_pkg;
  localparam int VEC_W = 128;
  localparam int OPD_W = 64;

  typedef enum logic [2:0] {
    RND_NEAR_EVEN = 3'd0,
    RND_UP        = 3'd1,
    RND_DOWN      = 3'd2,
    RND_ZERO      = 3'd3,
    RND_AWAY      = 3'd4
  } rnd_mode_e;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'b00,
    FMT_DOUBLE = 2'b01,
    FMT_BAD    = 2'b10,
    FMT_HALF   = 2'b11
  } fmt_code_e;

  typedef struct packed {
    rnd_mode_e mode;
    logic      report_inexact;
    logic      illegal;
  } rnd_ctl_t;
endpackage

// File: rtl/fpri_decode.sv
module fpri_decode
  import fpri_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic [1:0] fmt_code,
  input  logic [2:0] mode_field,
  input  logic [1:0] dyn_mode,
  output logic       sel_half,
  output logic       sel_single,
  output logic       sel_double,
  output rnd_ctl_t   ctl,
  output logic       undef
);
  logic fmt_bad;

  always_comb begin
    sel_half   = 1'b0;
    sel_single = 1'b0;
    sel_double = 1'b0;
    fmt_bad    = 1'b0;
    unique case (fmt_code)
      FMT_SINGLE: sel_single = 1'b1;
      FMT_DOUBLE: sel_double = 1'b1;
      FMT_HALF: begin
        sel_half = HALF_EN;
        fmt_bad  = !HALF_EN;
      end
      default:    fmt_bad    = 1'b1;
    endcase
  end

  always_comb begin
    ctl.mode           = RND_NEAR_EVEN;
    ctl.report_inexact = 1'b0;
    ctl.illegal        = 1'b0;
    if (!mode_field[2]) begin
      ctl.mode = rnd_mode_e'({1'b0, mode_field[1:0]});
    end else begin
      unique case (mode_field[1:0])
        2'b00: ctl.mode = RND_AWAY;
        2'b01: ctl.illegal = 1'b1;
        2'b10: begin
          ctl.mode           = rnd_mode_e'({1'b0, dyn_mode});
          ctl.report_inexact = 1'b1;
        end
        default: ctl.mode = rnd_mode_e'({1'b0, dyn_mode});
      endcase
    end
  end

  assign undef = fmt_bad | ctl.illegal;
endmodule

// File: rtl/fpri_round_core.sv
module fpri_round_core
  import fpri_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] op,
  input  rnd_mode_e      mode,
  output logic [EW+FW:0] res,
  output logic           invalid,
  output logic           inexact
);
  localparam int          MW        = FW + 2;
  localparam logic [EW-1:0] BIAS    = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] EXP_MAX = {EW{1'b1}};
  localparam logic [EW:0] INT_LIMIT = {1'b0, BIAS} + (EW+1)'(FW);
  localparam logic [FW-1:0] QUIET_BIT = {1'b1, {(FW-1){1'b0}}};
  localparam logic [MW-1:0] ONE_M   = MW'(1);

  logic          sgn;
  logic [EW-1:0] ex;
  logic [FW-1:0] fr;
  logic [MW-1:0] mant;
  logic [EW:0]   sh;
  logic [MW-1:0] unit, fmask, half, frac_part, rounded;
  logic          rbit, sticky, lsb, up, half_or_more;

  assign sgn  = op[EW+FW];
  assign ex   = op[EW+FW-1:FW];
  assign fr   = op[FW-1:0];
  assign mant = {1'b0, 1'b1, fr};

  always_comb begin
    res          = op;
    invalid      = 1'b0;
    inexact      = 1'b0;
    sh           = '0;
    unit         = '0;
    fmask        = '0;
    half         = '0;
    frac_part    = '0;
    rounded      = '0;
    rbit         = 1'b0;
    sticky       = 1'b0;
    lsb          = 1'b0;
    up           = 1'b0;
    half_or_more = 1'b0;
    if (ex == EXP_MAX) begin
      if (fr != '0 && !fr[FW-1]) begin
        res     = {sgn, ex, fr | QUIET_BIT};
        invalid = 1'b1;
      end
    end else if (ex == '0 && fr == '0) begin
      res = op;
    end else if ({1'b0, ex} >= INT_LIMIT) begin
      res = op;
    end else if (ex < BIAS) begin
      inexact      = 1'b1;
      half_or_more = (ex == BIAS - EW'(1));
      case (mode)
        RND_NEAR_EVEN: up = half_or_more && (fr != '0);
        RND_AWAY:      up = half_or_more;
        RND_UP:        up = !sgn;
        RND_DOWN:      up = sgn;
        default:       up = 1'b0;
      endcase
      res = up ? {sgn, BIAS, {FW{1'b0}}} : {sgn, {EW{1'b0}}, {FW{1'b0}}};
    end else begin
      sh        = INT_LIMIT - {1'b0, ex};
      unit      = ONE_M << sh;
      fmask     = unit - ONE_M;
      half      = unit >> 1;
      frac_part = mant & fmask;
      rbit      = |(frac_part & half);
      sticky    = |(frac_part & (half - ONE_M));
      lsb       = |(mant & unit);
      inexact   = (frac_part != '0);
      case (mode)
        RND_NEAR_EVEN: up = rbit && (sticky || lsb);
        RND_AWAY:      up = rbit;
        RND_UP:        up = !sgn && inexact;
        RND_DOWN:      up = sgn && inexact;
        default:       up = 1'b0;
      endcase
      rounded = (mant & ~fmask) + (up ? unit : '0);
      res = {sgn,
             ex + {{(EW-1){1'b0}}, rounded[FW+1]},
             rounded[FW] ? rounded[FW-1:0] : {FW{1'b0}}};
    end
  end
endmodule

// File: rtl/fp_round_integral.sv
module fp_round_integral
  import fpri_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         fmt_code,
  input  logic [2:0]         mode_field,
  input  logic [1:0]         dyn_mode,
  input  logic               merge_en,
  input  logic [OPD_W-1:0]   operand,
  input  logic [VEC_W-1:0]   dest_old,
  output logic               out_valid,
  output logic [VEC_W-1:0]   result,
  output logic               undef,
  output logic               flag_invalid,
  output logic               flag_inexact
);
  localparam int HW = 16;
  localparam int SW = 32;
  localparam int DW = 64;

  logic [1:0]       rst_sync;
  logic             rst_q_n;
  logic             sel_half, sel_single, sel_double, dec_undef;
  rnd_ctl_t         ctl;
  logic [HW-1:0]    h_res;
  logic [SW-1:0]    s_res;
  logic [DW-1:0]    d_res;
  logic             h_inv, s_inv, d_inv, h_inx, s_inx, d_inx;
  logic [VEC_W-1:0] low_mask, elem, keep;
  logic             sel_inv, sel_inx;
  logic [VEC_W-1:0] nxt_result;
  logic             nxt_undef, nxt_invalid, nxt_inexact, nxt_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  fpri_decode #(.HALF_EN(HALF_EN)) u_decode (
    .fmt_code  (fmt_code),
    .mode_field(mode_field),
    .dyn_mode  (dyn_mode),
    .sel_half  (sel_half),
    .sel_single(sel_single),
    .sel_double(sel_double),
    .ctl       (ctl),
    .undef     (dec_undef)
  );

  generate
    if (HALF_EN) begin : g_half
      fpri_round_core #(.EW(5), .FW(10)) u_core_h (
        .op(operand[HW-1:0]), .mode(ctl.mode),
        .res(h_res), .invalid(h_inv), .inexact(h_inx)
      );
    end else begin : g_no_half
      assign h_res = '0;
      assign h_inv = 1'b0;
      assign h_inx = 1'b0;
    end
  endgenerate

  fpri_round_core #(.EW(8), .FW(23)) u_core_s (
    .op(operand[SW-1:0]), .mode(ctl.mode),
    .res(s_res), .invalid(s_inv), .inexact(s_inx)
  );

  fpri_round_core #(.EW(11), .FW(52)) u_core_d (
    .op(operand), .mode(ctl.mode),
    .res(d_res), .invalid(d_inv), .inexact(d_inx)
  );

  always_comb begin
    low_mask = '0;
    elem     = '0;
    sel_inv  = 1'b0;
    sel_inx  = 1'b0;
    if (sel_half) begin
      low_mask = {{(VEC_W-HW){1'b0}}, {HW{1'b1}}};
      elem     = {{(VEC_W-HW){1'b0}}, h_res};
      sel_inv  = h_inv;
      sel_inx  = h_inx;
    end else if (sel_single) begin
      low_mask = {{(VEC_W-SW){1'b0}}, {SW{1'b1}}};
      elem     = {{(VEC_W-SW){1'b0}}, s_res};
      sel_inv  = s_inv;
      sel_inx  = s_inx;
    end else if (sel_double) begin
      low_mask = {{(VEC_W-DW){1'b0}}, {DW{1'b1}}};
      elem     = {{(VEC_W-DW){1'b0}}, d_res};
      sel_inv  = d_inv;
      sel_inx  = d_inx;
    end
    keep = merge_en ? (dest_old & ~low_mask) : '0;
  end

  always_comb begin
    nxt_valid = in_valid;
    if (dec_undef) begin
      nxt_result  = '0;
      nxt_undef   = 1'b1;
      nxt_invalid = 1'b0;
      nxt_inexact = 1'b0;
    end else begin
      nxt_result  = keep | elem;
      nxt_undef   = 1'b0;
      nxt_invalid = sel_inv;
      nxt_inexact = sel_inx & ctl.report_inexact;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= nxt_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      result       <= '0;
      undef        <= 1'b0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else if (in_valid) begin
      result       <= nxt_result;
      undef        <= nxt_undef;
      flag_invalid <= nxt_invalid;
      flag_inexact <= nxt_inexact;
    end
  end
endmodule

// File: rtl/fpri_chk.sv
module fpri_chk (
  input logic         clk,
  input logic         rst_q_n,
  input logic         in_valid,
  input logic [1:0]   fmt_code,
  input logic [2:0]   mode_field,
  input logic         merge_en,
  input logic [95:0]  dest_hi,
  input logic         out_valid,
  input logic [127:0] result,
  input logic         undef,
  input logic         flag_invalid,
  input logic         flag_inexact
);
  logic legal_mode;
  assign legal_mode = (mode_field != 3'b101);

  a_r1_bad_format: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && fmt_code == 2'b10 |=> undef);

  a_r2_bad_mode: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && !legal_mode |=> undef);

  a_r1_undef_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    undef |-> result == '0 && !flag_invalid && !flag_inexact);

  a_r10_silent_modes: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && mode_field != 3'b110 |=> !flag_inexact);

  a_r11_zero_upper: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && !merge_en && fmt_code == 2'b01 && legal_mode |=> result[127:64] == '0);

  a_r11_merge_upper: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && merge_en && fmt_code == 2'b00 && legal_mode |=> result[127:32] == $past(dest_hi));

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);

  a_r12_valid_drops: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> $stable(result) && $stable(undef));
endmodule

bind fp_round_integral fpri_chk u_fpri_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .in_valid    (in_valid),
  .fmt_code    (fmt_code),
  .mode_field  (mode_field),
  .merge_en    (merge_en),
  .dest_hi     (dest_old[127:32]),
  .out_valid   (out_valid),
  .result      (result),
  .undef       (undef),
  .flag_invalid(flag_invalid),
  .flag_inexact(flag_inexact)
);

// File: tb/test_fp_round_integral.sv
module test_fp_round_integral;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   fmt_code;
  logic [2:0]   mode_field;
  logic [1:0]   dyn_mode;
  logic         merge_en;
  logic [63:0]  operand;
  logic [127:0] dest_old;
  logic         out_valid;
  logic [127:0] result;
  logic         undef;
  logic         flag_invalid;
  logic         flag_inexact;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [127:0] PATTERN = 128'hA5A5_5A5A_C3C3_3C3C_0F0F_F0F0_1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_round_integral i_fp_round_integral (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_code(fmt_code),
    .mode_field(mode_field), .dyn_mode(dyn_mode), .merge_en(merge_en),
    .operand(operand), .dest_old(dest_old), .out_valid(out_valid),
    .result(result), .undef(undef), .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] f, input logic [2:0] m, input logic [1:0] d,
                        input logic mg, input logic [63:0] op, input logic [127:0] old);
    fmt_code   = f;
    mode_field = m;
    dyn_mode   = d;
    merge_en   = mg;
    operand    = op;
    dest_old   = old;
    in_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12 out_valid after op", {127'b0, out_valid}, 128'd1);
  endtask

  task automatic single_case(input string req, input logic [2:0] m, input logic [1:0] d,
                             input logic [31:0] op, input logic [31:0] exp,
                             input logic inx_exp);
    run_op(2'b00, m, d, 1'b0, {32'b0, op}, PATTERN);
    chk(req, result, {96'b0, exp});
    chk({req, " inexact"}, {127'b0, flag_inexact}, {127'b0, inx_exp});
  endtask

  task automatic t_reset();
    chk("R12 reset out_valid", {127'b0, out_valid}, 128'd0);
    chk("R12 reset result", result, 128'd0);
    chk("R12 reset flags", {126'b0, flag_invalid, flag_inexact}, 128'd0);
  endtask

  task automatic t_ties_away();
    single_case("R3 2.5 away", 3'b100, 2'b00, 32'h4020_0000, 32'h4040_0000, 1'b0);
    single_case("R3 -2.5 away", 3'b100, 2'b00, 32'hC020_0000, 32'hC040_0000, 1'b0);
    single_case("R3 0.5 away", 3'b100, 2'b00, 32'h3F00_0000, 32'h3F80_0000, 1'b0);
  endtask

  task automatic t_nearest_even();
    single_case("R4 2.5 even", 3'b000, 2'b00, 32'h4020_0000, 32'h4000_0000, 1'b0);
    single_case("R4 0.5 even", 3'b000, 2'b00, 32'h3F00_0000, 32'h0000_0000, 1'b0);
    single_case("R4 2.75 even", 3'b000, 2'b00, 32'h4030_0000, 32'h4040_0000, 1'b0);
  endtask

  task automatic t_carry();
    single_case("R9 3.5 even", 3'b000, 2'b00, 32'h4060_0000, 32'h4080_0000, 1'b0);
    single_case("R9 1.5 even", 3'b000, 2'b00, 32'h3FC0_0000, 32'h4000_0000, 1'b0);
    single_case("R9 1.75 up", 3'b001, 2'b00, 32'h3FE0_0000, 32'h4000_0000, 1'b0);
  endtask

  task automatic t_static_modes();
    single_case("R2 -2.5 down", 3'b010, 2'b00, 32'hC020_0000, 32'hC040_0000, 1'b0);
    single_case("R2 -2.5 zero", 3'b011, 2'b00, 32'hC020_0000, 32'hC000_0000, 1'b0);
    single_case("R2 2.25 up", 3'b001, 2'b00, 32'h4010_0000, 32'h4040_0000, 1'b0);
    single_case("R2 dyn down", 3'b111, 2'b10, 32'h4020_0000, 32'h4000_0000, 1'b0);
  endtask

  task automatic t_small();
    single_case("R8 -0.3 zero", 3'b011, 2'b00, 32'hBE99_999A, 32'h8000_0000, 1'b0);
    single_case("R8 -0.3 down", 3'b010, 2'b00, 32'hBE99_999A, 32'hBF80_0000, 1'b0);
    single_case("R8 -0.3 up", 3'b001, 2'b00, 32'hBE99_999A, 32'h8000_0000, 1'b0);
    single_case("R8 subnormal up", 3'b001, 2'b00, 32'h0000_0001, 32'h3F80_0000, 1'b0);
  endtask

  task automatic t_specials();
    single_case("R5 -inf", 3'b110, 2'b01, 32'hFF80_0000, 32'hFF80_0000, 1'b0);
    single_case("R5 -zero", 3'b110, 2'b01, 32'h8000_0000, 32'h8000_0000, 1'b0);
    single_case("R7 large", 3'b110, 2'b11, 32'h4B00_0001, 32'h4B00_0001, 1'b0);
  endtask

  task automatic t_nan();
    single_case("R6 snan", 3'b000, 2'b00, 32'h7F80_0001, 32'h7FC0_0001, 1'b0);
    chk("R6 snan invalid", {127'b0, flag_invalid}, 128'd1);
    single_case("R6 qnan", 3'b000, 2'b00, 32'h7FC0_0005, 32'h7FC0_0005, 1'b0);
    chk("R6 qnan no flag", {127'b0, flag_invalid}, 128'd0);
    run_op(2'b11, 3'b000, 2'b00, 1'b0, 64'h7C01, PATTERN);
    chk("R6 half snan", result, 128'h7E01);
    chk("R6 half snan invalid", {127'b0, flag_invalid}, 128'd1);
  endtask

  task automatic t_inexact();
    single_case("R10 report 2.5", 3'b110, 2'b00, 32'h4020_0000, 32'h4000_0000, 1'b1);
    single_case("R10 exact 2.0", 3'b110, 2'b00, 32'h4000_0000, 32'h4000_0000, 1'b0);
    run_op(2'b01, 3'b111, 2'b10, 1'b0, 64'hBFF8_0000_0000_0000, PATTERN);
    chk("R10 silent dyn double", result, {64'b0, 64'hC000_0000_0000_0000});
    chk("R10 silent flag", {127'b0, flag_inexact}, 128'd0);
    run_op(2'b01, 3'b110, 2'b10, 1'b0, 64'hBFF8_0000_0000_0000, PATTERN);
    chk("R10 reporting flag", {127'b0, flag_inexact}, 128'd1);
  endtask

  task automatic t_formats();
    run_op(2'b01, 3'b100, 2'b00, 1'b0, 64'h4004_0000_0000_0000, PATTERN);
    chk("R1 double away", result, {64'b0, 64'h4008_0000_0000_0000});
    run_op(2'b11, 3'b100, 2'b00, 1'b0, 64'h4100, PATTERN);
    chk("R1 half away", result, 128'h4200);
    run_op(2'b11, 3'b000, 2'b00, 1'b0, 64'h3E00, PATTERN);
    chk("R9 half carry", result, 128'h4000);
  endtask

  task automatic t_merge();
    run_op(2'b00, 3'b100, 2'b00, 1'b1, 64'h4020_0000, PATTERN);
    chk("R11 merge single", result, {PATTERN[127:32], 32'h4040_0000});
    run_op(2'b11, 3'b100, 2'b00, 1'b1, 64'h4100, PATTERN);
    chk("R11 merge half", result, {PATTERN[127:16], 16'h4200});
    run_op(2'b01, 3'b100, 2'b00, 1'b1, 64'h4004_0000_0000_0000, PATTERN);
    chk("R11 merge double", result, {PATTERN[127:64], 64'h4008_0000_0000_0000});
    run_op(2'b00, 3'b100, 2'b00, 1'b0, 64'h4020_0000, PATTERN);
    chk("R11 zero upper", result, {96'b0, 32'h4040_0000});
  endtask

  task automatic t_undef();
    run_op(2'b10, 3'b000, 2'b00, 1'b1, 64'h7F80_0001, PATTERN);
    chk("R1 fmt 10 undef", {127'b0, undef}, 128'd1);
    chk("R1 fmt 10 result", result, 128'd0);
    chk("R1 fmt 10 flags", {126'b0, flag_invalid, flag_inexact}, 128'd0);
    run_op(2'b00, 3'b101, 2'b00, 1'b1, 64'h4020_0000, PATTERN);
    chk("R2 mode 101 undef", {127'b0, undef}, 128'd1);
    chk("R2 mode 101 result", result, 128'd0);
    run_op(2'b00, 3'b100, 2'b00, 1'b0, 64'h4020_0000, PATTERN);
    chk("R2 legal clears undef", {127'b0, undef}, 128'd0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R12 idle out_valid", {127'b0, out_valid}, 128'd0);
    chk("R12 idle hold", result, {96'b0, 32'h4040_0000});
  endtask

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    fmt_code   = 2'b00;
    mode_field = 3'b000;
    dyn_mode   = 2'b00;
    merge_en   = 1'b0;
    operand    = '0;
    dest_old   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ties_away();
    t_nearest_even();
    t_carry();
    t_static_modes();
    t_small();
    t_specials();
    t_nan();
    t_inexact();
    t_formats();
    t_merge();
    t_undef();
    t_idle();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule